// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block is the tag side of a set-associative cache. Every way of every set holds a line address, a permission state and an optional lock owner. A controller issues one command per cycle. The command kinds are:

- an access check qualified by request kind
- a presence query
- an availability query
- allocation and deallocation
- a victim probe
- a permission write
- lock set, lock clear and lock test
- a read of the address held at a flat entry index

A tag match by itself does not make an access succeed. The permission of the matching way and the kind of request decide the result. Ways in the not-present state count as free slots. Each set keeps true least-recently-used order for victim selection.

Every command is accepted with a valid/ready handshake. Its result appears on registered outputs one cycle later. Data storage, coherence decisions, bank timing and statistics belong to other blocks.

Top module: `tagdir_top`

## Requirements
- R1: The set index is the SET_W-bit field of the address starting at bit INDEX_LSB. SETS = CACHE_BYTES / WAYS / LINE_BYTES. The low log2(LINE_BYTES) address bits are ignored, both for matching and for the stored address.
- R2: `req_ready` is low while reset is held and high from the first cycle after reset. An accepted request gives `rsp_valid` high on the next cycle, and in every cycle with no accepted request `rsp_valid` is low and all result outputs are zero. Op codes: 0 access, 1 presence, 2 availability, 3 allocate, 4 deallocate, 5 probe, 6 permission write, 7 lock set, 8 lock clear, 9 lock test, 10 index read.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only, 3 read-write, 4 busy. Request kinds are 0 load, 1 fetch and 2 store. An access is granted when the matching way is read-write, or when it is read-only and the kind is load or fetch. Everything else is denied. A way in the not-present state never gives a hit. `rsp_way` gives the matching way, or 0 on a miss.
- R4: An access that hits makes that way the most recently used, even when it is denied. A miss changes no recency.
- R5: A presence query reports a hit, with its way, when some way of the set holds the line in a state other than not-present. `rsp_grant` equals `rsp_hit`.
- R6: An availability query grants when a used way of the set holds the line in any state, or when some way is empty or not-present. `rsp_hit`/`rsp_way` report the line match regardless of its state.
- R7: Allocation fills the lowest-numbered empty or not-present way. It sets that way's state to invalid and clears its lock owner. It makes the way most recent only when `req_touch` is 1. It grants and returns that way.
- R8: Allocation while the line is already present, or while the set has no free way, changes no stored state. It raises `err_flag`, which stays high until reset.
- R9: A victim probe grants only when the set has no free way. It then returns the least recently used way and the line address it holds. Otherwise all its results are 0.
- R10: After reset, the recency order of each set runs from way 0 (newest) to way WAYS-1 (oldest).
- R11: Lock set records `req_ctx` on a present line. Lock clear removes the owner. Lock test grants only when an owner is recorded and equals `req_ctx`. On an absent line these commands grant 0 and change nothing.
- R12: An index read maps `req_idx` to set = idx / WAYS and way = idx mod WAYS. It returns that way in `rsp_way`. It returns the stored address with grant 1, or address 0 with grant 0 when the way is empty, invalid or not-present.
- R13: Deallocation empties the way holding a present line and grants. A permission write sets `req_perm` on the way matching the line in any state and grants. On no match, neither command changes anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block accepts a command |
| req_op | input | 4 | Command code |
| req_addr | input | ADDR_W | Byte address of the line |
| req_kind | input | 2 | Request kind for access checks |
| req_perm | input | 3 | State for the permission write |
| req_ctx | input | CTX_W | Requester context for lock commands |
| req_touch | input | 1 | Allocation updates recency |
| req_idx | input | IDX_W | Flat entry index for the index read |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Line match |
| rsp_way | output | WAY_W | Way index of the result |
| rsp_grant | output | 1 | Granted / true result |
| rsp_addr | output | ADDR_W | Victim or indexed line address |
| err_flag | output | 1 | Sticky allocation error |

## Verification
Every result, including the sticky error and the recency effect of a touch, is due on the clock edge right after the command is accepted. A later probe sees the recency change from the cycle after the touching command. The bench drives one command per clock on the falling edge, updates its behavioural model at the same moment, and compares every output on the next falling edge, half a cycle after the registers have loaded. Idle cycles are compared in the same way, so a result that comes a cycle early, comes late, or persists is reported as a miscompare.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_ABSENT = 3'd0,
        PERM_INVAL  = 3'd1,
        PERM_RDONLY = 3'd2,
        PERM_RDWR   = 3'd3,
        PERM_BUSY   = 3'd4
    } perm_e;

    typedef enum logic [3:0] {
        OP_ACCESS   = 4'd0,
        OP_PRESENT  = 4'd1,
        OP_AVAIL    = 4'd2,
        OP_ALLOC    = 4'd3,
        OP_DEALLOC  = 4'd4,
        OP_PROBE    = 4'd5,
        OP_SETPERM  = 4'd6,
        OP_LOCKSET  = 4'd7,
        OP_LOCKCLR  = 4'd8,
        OP_LOCKTEST = 4'd9,
        OP_READIDX  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_STORE = 2'd2
    } kind_e;

endpackage

// File: rtl/tagdir_decode.sv
module tagdir_decode #(
    parameter int ADDR_W    = 16,
    parameter int OFF_BITS  = 4,
    parameter int INDEX_LSB = 4,
    parameter int SET_W     = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SET_W-1:0]  set_o,
    output logic [ADDR_W-1:0] line_o
);
    localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << OFF_BITS) - ADDR_W'(1);

    always_comb begin
        line_o = addr_i & ~OFF_MASK;
        set_o  = addr_i[INDEX_LSB +: SET_W];
    end
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             used_i,
    input  logic [WAYS-1:0][2:0]        perm_i,
    input  logic [WAYS-1:0][ADDR_W-1:0] line_i,
    input  logic [ADDR_W-1:0]           key_i,
    output logic                        pres_hit_o,
    output logic [WAY_W-1:0]            pres_way_o,
    output logic                        any_hit_o,
    output logic [WAY_W-1:0]            any_way_o,
    output logic                        free_o,
    output logic [WAY_W-1:0]            free_way_o
);
    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] pres_eq;
    logic [WAYS-1:0] empty;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq[w]  = used_i[w] && (line_i[w] == key_i);
        assign pres_eq[w] = tag_eq[w] && (perm_i[w] != PERM_ABSENT);
        assign empty[w]   = !used_i[w] || (perm_i[w] == PERM_ABSENT);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        pres_hit_o = 1'b0;
        pres_way_o = '0;
        any_hit_o  = 1'b0;
        any_way_o  = '0;
        free_o     = 1'b0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (pres_eq[w]) begin
                pres_hit_o = 1'b1;
                pres_way_o = WAY_W'(w);
            end
            if (tag_eq[w]) begin
                any_hit_o = 1'b1;
                any_way_o = WAY_W'(w);
            end
            if (empty[w]) begin
                free_o     = 1'b1;
                free_way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [SET_W-1:0] tset_i,
    input  logic [WAY_W-1:0] tway_i,
    input  logic [SET_W-1:0] qset_i,
    output logic [WAY_W-1:0] victim_o
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tway_i) begin
                    age_d[tset_i][w] = '0;
                end else if (age_q[tset_i][w] < age_q[tset_i][tway_i]) begin
                    age_d[tset_i][w] = age_q[tset_i][w] + WAY_W'(1);
                end
            end
        end
    end

    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[qset_i][w] == OLDEST) begin
                victim_o = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            age_q <= age_d;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set_chk
        logic [WAYS-1:0] is_old;
        for (genvar w = 0; w < WAYS; w++) begin : g_w
            assign is_old[w] = (age_q[s][w] == OLDEST);
        end
        // R10
        single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(is_old) == 1);
    end

    // R4
    touched_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> age_q[$past(tset_i)][$past(tway_i)] == '0);
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
    import tagdir_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CACHE_BYTES = 256,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 16,
    parameter int INDEX_LSB   = 4,
    parameter int CTX_W       = 4,
    localparam int SETS     = CACHE_BYTES / WAYS / LINE_BYTES,
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int OFF_BITS = $clog2(LINE_BYTES),
    localparam int IDX_W    = $clog2(SETS * WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_perm,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_touch,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_grant,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              err_flag
);
    typedef struct packed {
        logic              used;
        logic [ADDR_W-1:0] line;
        logic [2:0]        perm;
        logic              lkv;
        logic [CTX_W-1:0]  owner;
    } way_t;

    typedef struct packed {
        way_t [SETS-1:0][WAYS-1:0] ways;
        logic                      ready;
        logic                      vld;
        logic [3:0]                op;
        logic                      hit;
        logic [WAY_W-1:0]          way;
        logic                      grant;
        logic [ADDR_W-1:0]         addr;
        logic                      err;
    } state_t;

    state_t s_d, s_q;

    logic [SET_W-1:0]             a_set;
    logic [ADDR_W-1:0]            a_line;
    logic [SET_W-1:0]             x_set;
    logic [WAY_W-1:0]             x_way;
    logic [WAYS-1:0]              row_used;
    logic [WAYS-1:0][2:0]         row_perm;
    logic [WAYS-1:0][ADDR_W-1:0]  row_line;
    logic                         pres_hit, any_hit, free_any;
    logic [WAY_W-1:0]             pres_way, any_way, free_way;
    logic [WAY_W-1:0]             victim;
    logic                         touch_en;
    logic [WAY_W-1:0]             touch_way;
    logic                         fire;
    way_t                         hw;
    way_t                         xw;
    logic                         rd_ok;

    tagdir_decode #(
        .ADDR_W   (ADDR_W),
        .OFF_BITS (OFF_BITS),
        .INDEX_LSB(INDEX_LSB),
        .SET_W    (SET_W)
    ) u_decode (
        .addr_i (req_addr),
        .set_o  (a_set),
        .line_o (a_line)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_used[w] = s_q.ways[a_set][w].used;
            row_perm[w] = s_q.ways[a_set][w].perm;
            row_line[w] = s_q.ways[a_set][w].line;
        end
    end

    tagdir_match #(
        .WAYS  (WAYS),
        .ADDR_W(ADDR_W)
    ) u_match (
        .used_i     (row_used),
        .perm_i     (row_perm),
        .line_i     (row_line),
        .key_i      (a_line),
        .pres_hit_o (pres_hit),
        .pres_way_o (pres_way),
        .any_hit_o  (any_hit),
        .any_way_o  (any_way),
        .free_o     (free_any),
        .free_way_o (free_way)
    );

    tagdir_lru #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_i  (touch_en),
        .tset_i   (a_set),
        .tway_i   (touch_way),
        .qset_i   (a_set),
        .victim_o (victim)
    );

    always_comb begin
        fire      = req_valid && s_q.ready;
        x_set     = SET_W'(32'(req_idx) / WAYS);
        x_way     = WAY_W'(32'(req_idx) % WAYS);
        hw        = s_q.ways[a_set][pres_way];
        xw        = s_q.ways[x_set][x_way];
        rd_ok     = xw.used && (xw.perm != PERM_ABSENT) && (xw.perm != PERM_INVAL);
        touch_en  = 1'b0;
        touch_way = pres_way;

        s_d       = s_q;
        s_d.ready = 1'b1;
        s_d.vld   = 1'b0;
        s_d.op    = '0;
        s_d.hit   = 1'b0;
        s_d.way   = '0;
        s_d.grant = 1'b0;
        s_d.addr  = '0;

        if (fire) begin
            s_d.vld = 1'b1;
            s_d.op  = req_op;
            case (req_op)
                OP_ACCESS: begin
                    s_d.hit   = pres_hit;
                    s_d.way   = pres_hit ? pres_way : '0;
                    s_d.grant = pres_hit && ((hw.perm == PERM_RDWR) ||
                                ((hw.perm == PERM_RDONLY) &&
                                 ((req_kind == KIND_LOAD) || (req_kind == KIND_FETCH))));
                    touch_en  = pres_hit;
                end
                OP_PRESENT, OP_LOCKSET, OP_LOCKCLR, OP_DEALLOC: begin
                    s_d.hit   = pres_hit;
                    s_d.way   = pres_hit ? pres_way : '0;
                    s_d.grant = pres_hit;
                    if (pres_hit) begin
                        if (req_op == OP_LOCKSET) begin
                            s_d.ways[a_set][pres_way].lkv   = 1'b1;
                            s_d.ways[a_set][pres_way].owner = req_ctx;
                        end else if (req_op == OP_LOCKCLR) begin
                            s_d.ways[a_set][pres_way].lkv   = 1'b0;
                            s_d.ways[a_set][pres_way].owner = '0;
                        end else if (req_op == OP_DEALLOC) begin
                            s_d.ways[a_set][pres_way] = '0;
                        end
                    end
                end
                OP_LOCKTEST: begin
                    s_d.hit   = pres_hit;
                    s_d.way   = pres_hit ? pres_way : '0;
                    s_d.grant = pres_hit && hw.lkv && (hw.owner == req_ctx);
                end
                OP_AVAIL: begin
                    s_d.hit   = any_hit;
                    s_d.way   = any_hit ? any_way : '0;
                    s_d.grant = any_hit || free_any;
                end
                OP_SETPERM: begin
                    s_d.hit   = any_hit;
                    s_d.way   = any_hit ? any_way : '0;
                    s_d.grant = any_hit;
                    if (any_hit) begin
                        s_d.ways[a_set][any_way].perm = req_perm;
                    end
                end
                OP_ALLOC: begin
                    s_d.hit = pres_hit;
                    if (free_any && !pres_hit) begin
                        s_d.grant                          = 1'b1;
                        s_d.way                            = free_way;
                        s_d.ways[a_set][free_way].used     = 1'b1;
                        s_d.ways[a_set][free_way].line     = a_line;
                        s_d.ways[a_set][free_way].perm     = PERM_INVAL;
                        s_d.ways[a_set][free_way].lkv      = 1'b0;
                        s_d.ways[a_set][free_way].owner    = '0;
                        touch_en                           = req_touch;
                        touch_way                          = free_way;
                    end else begin
                        s_d.way = pres_hit ? pres_way : '0;
                        s_d.err = 1'b1;
                    end
                end
                OP_PROBE: begin
                    s_d.grant = !free_any;
                    s_d.way   = free_any ? '0 : victim;
                    s_d.addr  = free_any ? '0 : row_line[victim];
                end
                OP_READIDX: begin
                    s_d.way   = x_way;
                    s_d.grant = rd_ok;
                    s_d.addr  = rd_ok ? xw.line : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = s_q.ready;
    assign rsp_valid = s_q.vld;
    assign rsp_hit   = s_q.hit;
    assign rsp_way   = s_q.way;
    assign rsp_grant = s_q.grant;
    assign rsp_addr  = s_q.addr;
    assign err_flag  = s_q.err;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid && !rsp_grant && !rsp_hit);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R3
    grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (s_q.op == OP_ACCESS) && rsp_grant) |-> rsp_hit);

    // R9
    probe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == OP_PROBE) && free_any) |=> !rsp_grant);
endmodule

// File: tb/tagdir_top_test.sv
module tagdir_top_test;
    localparam int NS = 4;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_perm = '0;
    logic [3:0]  req_ctx = '0;
    logic        req_touch = 1'b0;
    logic [3:0]  req_idx = '0;
    logic        rsp_valid, rsp_hit, rsp_grant, err_flag;
    logic [1:0]  rsp_way;
    logic [15:0] rsp_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tagdir_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm),
        .req_ctx(req_ctx), .req_touch(req_touch), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_grant(rsp_grant), .rsp_addr(rsp_addr), .err_flag(err_flag)
    );

    // behavioural reference state
    int          m_used [NS][NW];
    int          m_perm [NS][NW];
    int          m_lkv  [NS][NW];
    int          m_own  [NS][NW];
    logic [15:0] m_line [NS][NW];
    int          order  [NS][NW];   // order[s][0] newest, order[s][NW-1] oldest
    int          m_err;

    int          e_vld, e_hit, e_way, e_grant, e_err;
    logic [15:0] e_addr;

    task automatic touch(input int s, input int w);
        int pos = 0;
        for (int i = 0; i < NW; i++) if (order[s][i] == w) pos = i;
        for (int i = pos; i > 0; i--) order[s][i] = order[s][i-1];
        order[s][0] = w;
    endtask

    task automatic model(input int op, input logic [15:0] addr, input int kind,
                         input int perm, input int ctx, input int tch, input int idx);
        int s = (addr >> 4) & 3;
        logic [15:0] ln = addr & 16'hFFF0;
        int pw = -1;
        int aw = -1;
        int fw = -1;
        e_vld = 1; e_hit = 0; e_way = 0; e_grant = 0; e_addr = '0;
        for (int w = 0; w < NW; w++) begin
            if (m_used[s][w] != 0 && m_line[s][w] == ln) begin
                if (aw < 0) aw = w;
                if (m_perm[s][w] != 0 && pw < 0) pw = w;
            end
            if ((m_used[s][w] == 0 || m_perm[s][w] == 0) && fw < 0) fw = w;
        end
        case (op)
            0: begin
                if (pw >= 0) begin
                    e_hit = 1; e_way = pw;
                    e_grant = (m_perm[s][pw] == 3 || (m_perm[s][pw] == 2 && kind < 2)) ? 1 : 0;
                    touch(s, pw);
                end
            end
            1, 4, 7, 8, 9: begin
                if (pw >= 0) begin
                    e_hit = 1; e_way = pw; e_grant = 1;
                    if (op == 4) begin m_used[s][pw] = 0; m_lkv[s][pw] = 0; end
                    if (op == 7) begin m_lkv[s][pw] = 1; m_own[s][pw] = ctx; end
                    if (op == 8) m_lkv[s][pw] = 0;
                    if (op == 9) e_grant = (m_lkv[s][pw] != 0 && m_own[s][pw] == ctx) ? 1 : 0;
                end
            end
            2: begin
                e_hit = (aw >= 0); e_way = (aw >= 0) ? aw : 0;
                e_grant = (aw >= 0 || fw >= 0) ? 1 : 0;
            end
            6: begin
                if (aw >= 0) begin
                    e_hit = 1; e_way = aw; e_grant = 1; m_perm[s][aw] = perm;
                end
            end
            3: begin
                e_hit = (pw >= 0);
                if (fw >= 0 && pw < 0) begin
                    e_grant = 1; e_way = fw;
                    m_used[s][fw] = 1; m_line[s][fw] = ln; m_perm[s][fw] = 1;
                    m_lkv[s][fw] = 0; m_own[s][fw] = 0;
                    if (tch != 0) touch(s, fw);
                end else begin
                    e_way = (pw >= 0) ? pw : 0;
                    m_err = 1;
                end
            end
            5: begin
                if (fw < 0) begin
                    e_grant = 1; e_way = order[s][NW-1];
                    e_addr = m_line[s][order[s][NW-1]];
                end
            end
            10: begin
                int xs = idx / NW;
                int xw = idx % NW;
                e_way = xw;
                if (m_used[xs][xw] != 0 && m_perm[xs][xw] > 1) begin
                    e_grant = 1; e_addr = m_line[xs][xw];
                end
            end
            default: ;
        endcase
        e_err = m_err;
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (rsp_valid !== 1'(e_vld) || rsp_hit !== 1'(e_hit) || rsp_way !== 2'(e_way) ||
            rsp_grant !== 1'(e_grant) || rsp_addr !== e_addr || err_flag !== 1'(e_err) ||
            req_ready !== 1'b1) begin
            fails++;
            $display("FAIL %s: got vld=%0d hit=%0d way=%0d grant=%0d addr=%h err=%0d rdy=%0d exp vld=%0d hit=%0d way=%0d grant=%0d addr=%h err=%0d rdy=1",
                     tag, rsp_valid, rsp_hit, rsp_way, rsp_grant, rsp_addr, err_flag, req_ready,
                     e_vld, e_hit, e_way, e_grant, e_addr, e_err);
        end
    endtask

    // drive on a falling edge, compare on the next falling edge
    task automatic step(input string tag, input int v, input int op, input int addr,
                        input int kind = 0, input int perm = 0, input int ctx = 0,
                        input int tch = 0, input int idx = 0);
        req_valid = 1'(v); req_op = 4'(op); req_addr = 16'(addr); req_kind = 2'(kind);
        req_perm = 3'(perm); req_ctx = 4'(ctx); req_touch = 1'(tch); req_idx = 4'(idx);
        if (v != 0) model(op, 16'(addr), kind, perm, ctx, tch, idx);
        else begin
            e_vld = 0; e_hit = 0; e_way = 0; e_grant = 0; e_addr = '0; e_err = m_err;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lf = 32'h1ACE_B00C;
        m_err = 0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_used[s][w] = 0; m_perm[s][w] = 0; m_lkv[s][w] = 0;
                m_own[s][w] = 0; m_line[s][w] = '0; order[s][w] = w;
            end

        // R2: reset state
        repeat (3) @(negedge clk);
        check_bit("R2 ready in reset", req_ready, 1'b0);
        check_bit("R2 rsp_valid in reset", rsp_valid, 1'b0);
        check_bit("R8 err in reset", err_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R2 ready after reset", req_ready, 1'b1);

        step("R2 idle", 0, 0, 0);
        step("R5 presence miss", 1, 1, 'h0040);
        step("R6 avail empty set", 1, 2, 'h0040);
        step("R9 probe with free ways", 1, 5, 'h0000);
        step("R7 alloc first way", 1, 3, 'h0040, 0, 0, 0, 1);
        step("R5 presence hit invalid", 1, 1, 'h0047);
        step("R3 load to invalid", 1, 0, 'h0040, 0);
        step("R13 set read-only", 1, 6, 'h0040, 0, 2);
        step("R3 load read-only", 1, 0, 'h0040, 0);
        step("R3 fetch read-only", 1, 0, 'h0040, 1);
        step("R3 store read-only", 1, 0, 'h0040, 2);
        step("R13 set read-write", 1, 6, 'h0040, 0, 3);
        step("R3 store read-write", 1, 0, 'h004C, 2);
        step("R8 alloc already present", 1, 3, 'h0040);
        step("R8 err stays", 0, 0, 0);
        step("R7 alloc no touch", 1, 3, 'h0000, 0, 0, 0, 0);
        step("R7 alloc touch", 1, 3, 'h0080, 0, 0, 0, 1);
        step("R7 alloc last way", 1, 3, 'h00C0, 0, 0, 0, 0);
        step("R6 avail full miss", 1, 2, 'h0100);
        step("R6 avail full hit", 1, 2, 'h0080);
        step("R8 alloc full set", 1, 3, 'h0100);
        step("R8 state unchanged", 1, 1, 'h0100);
        step("R1 other set alloc", 1, 3, 'h0110, 0, 0, 0, 1);
        step("R9 R10 probe full", 1, 5, 'h0000);
        step("R4 set read-only c0", 1, 6, 'h00C0, 0, 2);
        step("R4 denied store touches", 1, 0, 'h00C0, 2);
        step("R9 probe after touch", 1, 5, 'h0000);
        step("R3 not-present perm", 1, 6, 'h0080, 0, 0);
        step("R3 access not-present", 1, 0, 'h0080, 0);
        step("R6 avail via not-present", 1, 2, 'h0100);
        step("R7 alloc reuses not-present", 1, 3, 'h0100, 0, 0, 0, 1);
        step("R11 lock set", 1, 7, 'h0040, 0, 0, 5);
        step("R11 lock test owner", 1, 9, 'h0040, 0, 0, 5);
        step("R11 lock test other", 1, 9, 'h0040, 0, 0, 3);
        step("R11 lock clear", 1, 8, 'h0040);
        step("R11 test after clear", 1, 9, 'h0040, 0, 0, 5);
        step("R11 lock absent line", 1, 7, 'h0300, 0, 0, 2);
        step("R11 lock before dealloc", 1, 7, 'h0000, 0, 0, 6);
        step("R13 dealloc", 1, 4, 'h0000);
        step("R13 dealloc miss", 1, 4, 'h0000);
        step("R7 realloc", 1, 3, 'h0000, 0, 0, 0, 0);
        step("R7 lock cleared by alloc", 1, 9, 'h0000, 0, 0, 6);
        step("R12 read idx rw", 1, 10, 0, 0, 0, 0, 0, 0);
        step("R12 read idx invalid", 1, 10, 0, 0, 0, 0, 0, 1);
        step("R12 read idx empty", 1, 10, 0, 0, 0, 0, 0, 13);
        step("R12 read idx set1", 1, 10, 0, 0, 0, 0, 0, 4);

        // mixed pseudo-random traffic across sets (R1..R13)
        for (int n = 0; n < 600; n++) begin
            int op, addr;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            op = int'(lf[7:0]) % 11;
            addr = (int'(lf[10:8]) % 6) * 64 + int'(lf[12:11]) * 16 + int'(lf[16:13]);
            if (lf[20:18] == 3'd0) step("R2 mixed idle", 0, 0, 0);
            else step("R1 mixed traffic", 1, op, addr, int'(lf[22:21]),
                      int'(lf[25:23]) % 5, int'(lf[27:26]), int'(lf[28]), int'(lf[31:28]));
        end
        step("R2 final idle", 0, 0, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule